// File: doc/BRIEF.md
# Eight-Region Address Protection Unit

This block checks and translates memory accesses for a core that has no paged MMU. The 32-bit virtual space is cut into eight fixed 512 MB slices. The top three address bits select the slice. Instruction fetches look up one table of eight entries, and loads and stores look up a second table of eight entries.

Each entry holds two fields:
- a 3-bit physical slice number, which is the translation;
- a 4-bit attribute code, which carries both the permissions and the cache policy.

The lookup is combinational. For each request it returns the physical address, the cache mode and, when the access is not allowed, a fault code.

Entries are changed through a synchronous write port. A write first affects lookups in the cycle after the clock edge that takes it. Reset sets both tables to an identity map with attribute 2, which allows read, write and execute with the cache bypassed.

Top module: `region_guard`

## Requirements
- R1: Virtual address bits [31:29] select one of eight entries in the table being used, and different slices are translated independently.
- R2: After reset, and again when reset is asserted after writes, every entry of both tables maps slice n to physical slice n with attribute 2. The result is no fault and cache mode bypass for loads, stores and fetches.
- R3: Attribute 0 allows read and write with write-through. Attribute 1 allows read, write and execute with write-through. Attribute 2 allows read, write and execute with bypass.
- R4: Attribute 3 allows execute only, with write-back. Attributes 4 and 5 allow read, write and execute with write-back.
- R5: Attribute 14 allows read and write in isolate mode. Every other attribute value allows nothing and reports cache mode bypass.
- R6: `req_kind` uses this encoding: 00 is a load, 01 is a store, and 1x is a fetch. Fetches use the instruction table. Loads and stores use the data table.
- R7: The fault code uses this encoding: 0 means no fault, 1 a load denied, 2 a store denied and 3 a fetch denied. `rsp_fault_vld` is high exactly when the code is non-zero.
- R8: `rsp_paddr` is the entry's physical slice in bits [31:29], ORed with virtual address bits [28:0]. It is driven this way for every request, including requests that fault.
- R9: When `wr_en` is high at a rising edge, it writes `wr_base` and `wr_attr` into entry `wr_idx`. The instruction table is written when `wr_instr` is 1, and the data table when it is 0. The new values are seen from the next cycle on. A cycle with `wr_en` low changes no entry.
- R10: The cache mode uses this encoding: 0 is bypass, 1 write-through, 2 write-back and 3 isolate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restores the identity map |
| wr_en | input | 1 | Entry write strobe |
| wr_instr | input | 1 | 1 selects the instruction table, 0 the data table |
| wr_idx | input | 3 | Entry index to write |
| wr_base | input | 3 | New physical slice number |
| wr_attr | input | 4 | New attribute code |
| req_addr | input | 32 | Virtual address of the access |
| req_kind | input | 2 | Access type (00 load, 01 store, 1x fetch) |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_cache | output | 2 | Cache mode of the access |
| rsp_fault_vld | output | 1 | High when the access is denied |
| rsp_fault | output | 2 | Fault cause code, 0 when no fault |

## Verification
The bench builds the block with its default parameters: a 32-bit address, eight slices and a 4-bit attribute. With these values all eight entries of both tables, and every defined attribute code, can be reached in a short run.

The two tables are loaded with different slice permutations and the same set of attributes. A result taken from the wrong table therefore shows up as a wrong physical slice. The undefined code 9 is also loaded, to exercise the no-access case. Separate directed steps cover three points:
- the edge at which a write becomes visible;
- a write strobe held low, which must change nothing;
- a second reset, which must restore the identity map.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;
   typedef enum logic [1:0] {
      CM_BYPASS  = 2'd0,
      CM_WTHRU   = 2'd1,
      CM_WBACK   = 2'd2,
      CM_ISOLATE = 2'd3
   } cache_mode_e;

   typedef enum logic [1:0] {
      FC_NONE  = 2'd0,
      FC_LOAD  = 2'd1,
      FC_STORE = 2'd2,
      FC_FETCH = 2'd3
   } fault_code_e;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } perm_t;
endpackage

// File: rtl/region_attr_decode.sv
module region_attr_decode
   import region_guard_pkg::*;
#(
   parameter int ATTR_W = 4
) (
   input  logic [ATTR_W-1:0] attr,
   output perm_t             perm,
   output cache_mode_e       cmode
);
   always_comb begin
      perm  = '0;
      cmode = CM_BYPASS;
      case (attr)
         ATTR_W'(0):  begin perm = '{rd:1'b1, wr:1'b1, ex:1'b0}; cmode = CM_WTHRU;   end
         ATTR_W'(1):  begin perm = '{rd:1'b1, wr:1'b1, ex:1'b1}; cmode = CM_WTHRU;   end
         ATTR_W'(2):  begin perm = '{rd:1'b1, wr:1'b1, ex:1'b1}; cmode = CM_BYPASS;  end
         ATTR_W'(3):  begin perm = '{rd:1'b0, wr:1'b0, ex:1'b1}; cmode = CM_WBACK;   end
         ATTR_W'(4),
         ATTR_W'(5):  begin perm = '{rd:1'b1, wr:1'b1, ex:1'b1}; cmode = CM_WBACK;   end
         ATTR_W'(14): begin perm = '{rd:1'b1, wr:1'b1, ex:1'b0}; cmode = CM_ISOLATE; end
         default:     begin perm = '0;                           cmode = CM_BYPASS;  end
      endcase
   end
endmodule

// File: rtl/region_access_check.sv
module region_access_check
   import region_guard_pkg::*;
(
   input  perm_t       perm,
   input  logic [1:0]  kind,
   output logic        deny,
   output fault_code_e code
);
   always_comb begin
      if (kind[1]) begin
         deny = !perm.ex;
         code = deny ? FC_FETCH : FC_NONE;
      end else if (kind[0]) begin
         deny = !perm.wr;
         code = deny ? FC_STORE : FC_NONE;
      end else begin
         deny = !perm.rd;
         code = deny ? FC_LOAD : FC_NONE;
      end
   end
endmodule

// File: rtl/region_table.sv
module region_table #(
   parameter int IDX_W      = 3,
   parameter int ATTR_W     = 4,
   parameter int RESET_ATTR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [IDX_W-1:0]  wbase,
   input  logic [ATTR_W-1:0] wattr,
   input  logic [IDX_W-1:0]  ridx,
   output logic [IDX_W-1:0]  rbase,
   output logic [ATTR_W-1:0] rattr
);
   localparam int NENT = 1 << IDX_W;

   logic [IDX_W-1:0]  base_q [NENT];
   logic [ATTR_W-1:0] attr_q [NENT];

   for (genvar e = 0; e < NENT; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[e] <= IDX_W'(e);
            attr_q[e] <= ATTR_W'(RESET_ATTR);
         end else if (we && widx == IDX_W'(e)) begin
            base_q[e] <= wbase;
            attr_q[e] <= wattr;
         end
      end
   end

   assign rbase = base_q[ridx];
   assign rattr = attr_q[ridx];
endmodule

// File: rtl/region_guard.sv
module region_guard
   import region_guard_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 3,
   parameter int ATTR_W     = 4,
   parameter int RESET_ATTR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_instr,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [IDX_W-1:0]  wr_base,
   input  logic [ATTR_W-1:0] wr_attr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_kind,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [1:0]        rsp_cache,
   output logic              rsp_fault_vld,
   output logic [1:0]        rsp_fault
);
   localparam int OFF_W = ADDR_W - IDX_W;
   localparam int NSIDE = 2;   // 0 = data table, 1 = instruction table

   if (ATTR_W != 4) begin : g_bad_attr
      $error("region_guard: ATTR_W must be 4");
   end
   if (IDX_W < 1 || OFF_W < 1) begin : g_bad_idx
      $error("region_guard: IDX_W must leave offset bits");
   end

   logic [IDX_W-1:0]  ridx;
   logic [IDX_W-1:0]  side_base [NSIDE];
   logic [ATTR_W-1:0] side_attr [NSIDE];

   assign ridx = req_addr[ADDR_W-1 -: IDX_W];

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      region_table #(
         .IDX_W      (IDX_W),
         .ATTR_W     (ATTR_W),
         .RESET_ATTR (RESET_ATTR)
      ) u_tbl (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en && (wr_instr == 1'(s))),
         .widx  (wr_idx),
         .wbase (wr_base),
         .wattr (wr_attr),
         .ridx  (ridx),
         .rbase (side_base[s]),
         .rattr (side_attr[s])
      );
   end

   logic              use_instr;
   logic [IDX_W-1:0]  sel_base;
   logic [ATTR_W-1:0] sel_attr;
   perm_t             perm;
   cache_mode_e       cmode;
   logic              deny;
   fault_code_e       code;

   assign use_instr = req_kind[1];
   assign sel_base  = use_instr ? side_base[1] : side_base[0];
   assign sel_attr  = use_instr ? side_attr[1] : side_attr[0];

   region_attr_decode #(.ATTR_W(ATTR_W)) u_dec (
      .attr  (sel_attr),
      .perm  (perm),
      .cmode (cmode)
   );

   region_access_check u_chk (
      .perm (perm),
      .kind (req_kind),
      .deny (deny),
      .code (code)
   );

   assign rsp_paddr     = {sel_base, req_addr[OFF_W-1:0]};
   assign rsp_cache     = cmode;
   assign rsp_fault_vld = deny;
   assign rsp_fault     = code;
endmodule

// File: rtl/region_guard_checker.sv
module region_guard_checker #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_kind,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic [1:0]        rsp_cache,
   input logic              rsp_fault_vld,
   input logic [1:0]        rsp_fault
);
   localparam int OFF_W = ADDR_W - IDX_W;

   logic pristine;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pristine <= 1'b1;
      else if (wr_en) pristine <= 1'b0;
   end

   p_flag_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault_vld == (rsp_fault != 2'd0));

   p_fetch_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_kind[1] && rsp_fault_vld) |-> rsp_fault == 2'd3);

   p_data_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_kind[1] && rsp_fault_vld) |-> rsp_fault == (req_kind[0] ? 2'd2 : 2'd1));

   p_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_paddr[OFF_W-1:0] == req_addr[OFF_W-1:0]);

   p_reset_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pristine |-> (rsp_paddr[ADDR_W-1 -: IDX_W] == req_addr[ADDR_W-1 -: IDX_W]
                    && !rsp_fault_vld && rsp_cache == 2'd0));

   p_isolate_no_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_cache == 2'd3 && req_kind[1]) |-> rsp_fault_vld);

   p_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && $stable(req_addr) && $stable(req_kind))
         |-> ($stable(rsp_paddr) && $stable(rsp_cache) && $stable(rsp_fault)));
endmodule

bind region_guard region_guard_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .req_addr      (req_addr),
   .req_kind      (req_kind),
   .rsp_paddr     (rsp_paddr),
   .rsp_cache     (rsp_cache),
   .rsp_fault_vld (rsp_fault_vld),
   .rsp_fault     (rsp_fault)
);

// File: tb/region_guard_tb.sv
module region_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_instr = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [2:0]  wr_base = '0;
   logic [3:0]  wr_attr = '0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_kind = '0;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_cache;
   logic        rsp_fault_vld;
   logic [1:0]  rsp_fault;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   region_guard u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_instr(wr_instr),
      .wr_idx(wr_idx), .wr_base(wr_base), .wr_attr(wr_attr),
      .req_addr(req_addr), .req_kind(req_kind), .rsp_paddr(rsp_paddr),
      .rsp_cache(rsp_cache), .rsp_fault_vld(rsp_fault_vld), .rsp_fault(rsp_fault)
   );

   // attribute loaded into entry i of both tables
   localparam logic [3:0] ATTRS [8] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd14, 4'd9};

   // {addr, kind, expected fault, expected cache}
   localparam logic [37:0] VEC [16] = '{
      {32'h0123_4567, 2'd0, 2'd0, 2'd1},   // R3 attr0 load ok
      {32'h1000_0ABC, 2'd2, 2'd3, 2'd1},   // R3 attr0 fetch denied
      {32'h2FED_CBA9, 2'd2, 2'd0, 2'd1},   // R3 attr1 fetch
      {32'h4000_0001, 2'd1, 2'd0, 2'd0},   // R3 attr2 store bypass
      {32'h6ABC_0000, 2'd0, 2'd1, 2'd2},   // R4 attr3 load denied
      {32'h7000_1111, 2'd1, 2'd2, 2'd2},   // R4 attr3 store denied
      {32'h6000_2222, 2'd2, 2'd0, 2'd2},   // R4 attr3 fetch ok
      {32'h8765_4321, 2'd1, 2'd0, 2'd2},   // R4 attr4 store
      {32'hB000_0FF0, 2'd2, 2'd0, 2'd2},   // R4 attr5 fetch
      {32'hC1C1_C1C1, 2'd1, 2'd0, 2'd3},   // R5 attr14 store isolate
      {32'hDFFF_FFFF, 2'd2, 2'd3, 2'd3},   // R5 attr14 fetch denied
      {32'hE000_0000, 2'd0, 2'd1, 2'd0},   // R5 attr9 load denied
      {32'hF0F0_0F0F, 2'd1, 2'd2, 2'd0},   // R5 attr9 store denied
      {32'hFFFF_FFFF, 2'd2, 2'd3, 2'd0},   // R5 attr9 fetch denied
      {32'hA555_AAAA, 2'd0, 2'd0, 2'd2},   // R4 attr5 load
      {32'h6111_2222, 2'd3, 2'd0, 2'd2}    // R6 kind 11 is a fetch
   };

   function automatic logic [2:0] data_slice(input logic [2:0] r);
      return 3'd7 - r;
   endfunction
   function automatic logic [2:0] instr_slice(input logic [2:0] r);
      return r + 3'd3;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic lookup(input logic [31:0] a, input logic [1:0] k);
      req_addr = a;
      req_kind = k;
      #1;
   endtask

   task automatic write_entry(input logic side, input logic [2:0] idx,
                              input logic [2:0] base, input logic [3:0] attr);
      @(negedge clk);
      wr_en = 1'b1; wr_instr = side; wr_idx = idx; wr_base = base; wr_attr = attr;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: identity map after reset
      for (int r = 0; r < 8; r++) begin
         for (int k = 0; k < 3; k++) begin
            lookup({3'(r), 29'h0055_AA11}, 2'(k));
            check("R2 reset paddr", 64'(rsp_paddr), 64'({3'(r), 29'h0055_AA11}));
            check("R2 reset cache", 64'(rsp_cache), 64'd0);
            check("R2 reset fault", 64'({rsp_fault_vld, rsp_fault}), 64'd0);
         end
      end

      // R9: write becomes visible only after the edge
      lookup(32'h2000_0040, 2'd0);
      @(negedge clk);
      wr_en = 1'b1; wr_instr = 1'b0; wr_idx = 3'd1; wr_base = 3'd6; wr_attr = 4'd3;
      #1;
      check("R9 old value before edge", 64'({rsp_paddr, rsp_fault}), 64'({32'h2000_0040, 2'd0}));
      @(posedge clk); #1;
      wr_en = 1'b0;
      check("R9 new paddr after edge", 64'(rsp_paddr), 64'(32'hC000_0040));
      check("R9 new fault after edge", 64'(rsp_fault), 64'd1);
      // R6: the instruction table is untouched by a data write
      lookup(32'h2000_0040, 2'd2);
      check("R6 instr table separate", 64'({rsp_paddr, rsp_fault_vld}), 64'({32'h2000_0040, 1'b0}));

      // R9: strobe low changes nothing
      @(negedge clk);
      wr_en = 1'b0; wr_instr = 1'b0; wr_idx = 3'd1; wr_base = 3'd0; wr_attr = 4'd2;
      @(negedge clk);
      lookup(32'h2000_0040, 2'd0);
      check("R9 no write when wr_en low", 64'({rsp_paddr, rsp_fault}), 64'({32'hC000_0040, 2'd1}));

      // load both tables
      for (int i = 0; i < 8; i++) begin
         write_entry(1'b0, 3'(i), data_slice(3'(i)), ATTRS[i]);
         write_entry(1'b1, 3'(i), instr_slice(3'(i)), ATTRS[i]);
      end

      // table walk: R1 R3 R4 R5 R6 R7 R8 R10
      for (int v = 0; v < 16; v++) begin
         logic [31:0] a;
         logic [1:0]  k;
         logic [2:0]  sl;
         a  = VEC[v][37:6];
         k  = VEC[v][5:4];
         sl = k[1] ? instr_slice(a[31:29]) : data_slice(a[31:29]);
         lookup(a, k);
         check("R8 R1 R6 paddr", 64'(rsp_paddr), 64'({sl, a[28:0]}));
         check("R7 fault code", 64'(rsp_fault), 64'(VEC[v][3:2]));
         check("R7 fault flag", 64'(rsp_fault_vld), 64'(VEC[v][3:2] != 2'd0));
         check("R10 cache mode", 64'(rsp_cache), 64'(VEC[v][1:0]));
      end

      // R2: reset again restores identity
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      lookup(32'hD234_5678, 2'd2);
      check("R2 re-reset fetch", 64'({rsp_paddr, rsp_cache, rsp_fault_vld}), 64'({32'hD234_5678, 2'd0, 1'b0}));
      lookup(32'h6234_5678, 2'd0);
      check("R2 re-reset load", 64'({rsp_paddr, rsp_cache, rsp_fault_vld}), 64'({32'h6234_5678, 2'd0, 1'b0}));

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule